// File: doc/BRIEF.md
# Variable-Length Bus Packet Framer

This block sits directly above a serial byte shifter on a multi-drop control bus. Each received byte comes in on a one-cycle valid strobe. The block collects the bytes into a single packet buffer that holds up to sixteen bytes. While no packet is in progress, the bus idles with zero bytes, and the framer drops them. The first non-zero byte opens a packet at buffer slot 0, and each later byte goes into the next slot, including any zero bytes inside the packet.

The third byte of a packet is the first command byte, and its two most significant bits select the packet size. When the third byte arrives, the framer latches the size. When the number of stored bytes reaches that size, it raises a one-cycle completion pulse. It then rewinds to slot 0 and clears the latched size.

The buffer is left intact after completion, so logic downstream can read it until the next packet overwrites it. A restart input clears the buffer, the position and the size at once, so a new packet cannot mix with stale bytes.

Top module: `pkt_framer`

## Requirements
- R1: When the write position is 0, a valid byte equal to 0x00 is discarded: no buffer byte changes and the position stays at 0.
- R2: Every other valid byte is written into buffer slot k, which appears on `pkt_buf[8k+7:8k]`, where k is the current position; the position then advances by one.
- R3: From the cycle after the third byte (slot 2) is accepted, `pkt_len` shows the size decoded from bits 7:6 of that byte: 00 or 01 gives 6, 10 gives 11, and 11 gives 16.
- R4: `pkt_done` is high for exactly one cycle, the cycle after the byte that makes the stored count equal the decoded size. It goes high once per packet.
- R5: On completion, the position returns to 0 and `pkt_len` reads 0, already in the cycle where `pkt_done` is high. Buffer contents stay unchanged until new bytes overwrite them, and the next packet again skips leading 0x00 bytes.
- R6: A high `restart` in a cycle clears every buffer byte, the position and `pkt_len` at the next edge. It takes priority over a valid byte in the same cycle, and that byte is lost.
- R7: `pkt_len` reads 0 while fewer than three bytes of the current packet are held. A 0x00 byte at any position other than 0 is stored like any other byte.
- R8: After synchronous reset (`rst_n` low at a clock edge), the buffer is all zero, `pkt_len` is 0 and `pkt_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_vld | input | 1 | One-cycle strobe: `byte_in` holds a received byte |
| byte_in | input | 8 | Received byte |
| restart | input | 1 | Clear the buffer and rewind the framer |
| pkt_buf | output | 128 | Packet buffer, slot k at bits 8k+7:8k |
| pkt_len | output | 5 | Decoded packet size (6, 11, 16), or 0 while unknown |
| pkt_done | output | 1 | One-cycle pulse when a packet is complete |

## Verification
The bench sends idle zeros both before and between packets, and checks that the buffer does not move. A framer that stored them would shift every later byte up by one slot. It sends a zero byte in the middle of a medium packet and a trailing zero in a long one. A design that applied the idle filter at every position would never complete those packets. It sends the 01 size pattern, which a decoder keyed on bit 6 alone would treat as a long packet. It also sends packets back to back and fires `restart` both in the middle of a packet and together with a valid byte. A framer with the wrong priority would leave a stray byte in slot 0 or keep an old size.

// File: rtl/pkt_framer_pkg.sv
// Package: shared types for the packet framer.
// Assumes: packet sizes come in three classes, selected by the first command byte.
package pkt_framer_pkg;

    // Size class decoded from the first command byte
    typedef enum logic [1:0] {
        SZ_SHORT = 2'd0,
        SZ_MED   = 2'd1,
        SZ_LONG  = 2'd2
    } pkt_size_e;

    // Map the two top bits of the command byte to a size class
    function automatic pkt_size_e size_of(input logic [1:0] top);
        case (top)
            2'b10:   size_of = SZ_MED;
            2'b11:   size_of = SZ_LONG;
            default: size_of = SZ_SHORT;
        endcase
    endfunction

endpackage

// File: rtl/pkt_len_decode.sv
// Module: pkt_len_decode
// Turns the first command byte into a packet length in bytes.
// Assumes: only the top bit asks for a longer packet; the next bit
// picks medium or long. The result is only used when that byte is accepted.
module pkt_len_decode #(
    parameter int DATA_W    = 8,
    parameter int LEN_W     = 5,
    parameter int LEN_SHORT = 6,
    parameter int LEN_MED   = 11,
    parameter int LEN_LONG  = 16
) (
    input  logic [DATA_W-1:0] cmd_byte,
    output logic [LEN_W-1:0]  dec_len
);
    import pkt_framer_pkg::*;

    pkt_size_e size_cls;

    // Classify, then map the class to a byte count
    always_comb begin
        size_cls = size_of(cmd_byte[DATA_W-1 -: 2]);
        case (size_cls)
            SZ_MED:  dec_len = LEN_W'(LEN_MED);
            SZ_LONG: dec_len = LEN_W'(LEN_LONG);
            default: dec_len = LEN_W'(LEN_SHORT);
        endcase
    end

endmodule

// File: rtl/pkt_seq_ctrl.sv
// Module: pkt_seq_ctrl
// Tracks the write position and the latched packet length, and decides
// which bytes get stored and when a packet is complete.
// Assumes: byte_vld is a one-cycle strobe; restart has priority over data.
module pkt_seq_ctrl #(
    parameter int POS_W   = 5,
    parameter int LEN_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             byte_vld,
    input  logic             byte_zero,
    input  logic [POS_W-1:0] dec_len,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_pos,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] len_q,
    output logic             done_q
);
    localparam logic [POS_W-1:0] LEN_AT = POS_W'(LEN_IDX + 1);

    logic             accept;
    logic [POS_W-1:0] pos_inc;
    logic [POS_W-1:0] len_now;
    logic             done_now;

    // Accept rule, next position, length in effect and completion test
    always_comb begin
        accept   = byte_vld && !((pos_q == '0) && byte_zero);
        pos_inc  = pos_q + 1'b1;
        len_now  = (pos_inc == LEN_AT) ? dec_len : len_q;
        done_now = accept && (len_now != '0) && (pos_inc == len_now);
    end

    assign wr_en  = accept && !restart;
    assign wr_pos = pos_q;

    // Position, length and completion pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= done_now;
            if (accept) begin
                if (done_now) begin
                    pos_q <= '0;
                    len_q <= '0;
                end else begin
                    pos_q <= pos_inc;
                    len_q <= len_now;
                end
            end
        end
    end

endmodule

// File: rtl/pkt_byte_store.sv
// Module: pkt_byte_store
// Packet buffer: one register per slot, written at the addressed slot,
// cleared as a whole by reset or clear.
// Assumes: at most one slot is written per cycle; clear wins over write.
module pkt_byte_store #(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 16,
    parameter int POS_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [POS_W-1:0]            wr_pos,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [MAX_BYTES*DATA_W-1:0] buf_flat
);
    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_slot
        logic [DATA_W-1:0] slot_q;

        // Hold one packet byte; load when addressed
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slot_q <= '0;
            end else if (wr_en && (wr_pos == POS_W'(i))) begin
                slot_q <= wr_data;
            end
        end

        assign buf_flat[i*DATA_W +: DATA_W] = slot_q;
    end

endmodule

// File: rtl/pkt_framer.sv
// Module: pkt_framer (top)
// Assembles bytes from the bus shifter into a packet buffer, skipping
// idle zero bytes, sizing the packet from its first command byte, and
// pulsing pkt_done when the packet is full.
// Assumes: bytes arrive as single-cycle strobes; checksums and command
// meaning are handled downstream.
module pkt_framer #(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 16,
    parameter int LEN_IDX   = 2,
    parameter int LEN_SHORT = 6,
    parameter int LEN_MED   = 11,
    parameter int LEN_LONG  = 16
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            byte_vld,
    input  logic [DATA_W-1:0]                               byte_in,
    input  logic                                            restart,
    output logic [MAX_BYTES*DATA_W-1:0]                     pkt_buf,
    output logic [$clog2(MAX_BYTES+1)-1:0]                  pkt_len,
    output logic                                            pkt_done
);
    localparam int POS_W = $clog2(MAX_BYTES + 1);

    logic [POS_W-1:0] dec_len;
    logic [POS_W-1:0] wr_pos;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] len_q;
    logic             wr_en;
    logic             byte_zero;

    assign byte_zero = (byte_in == '0);

    pkt_len_decode #(
        .DATA_W   (DATA_W),
        .LEN_W    (POS_W),
        .LEN_SHORT(LEN_SHORT),
        .LEN_MED  (LEN_MED),
        .LEN_LONG (LEN_LONG)
    ) u_dec (
        .cmd_byte(byte_in),
        .dec_len (dec_len)
    );

    pkt_seq_ctrl #(
        .POS_W  (POS_W),
        .LEN_IDX(LEN_IDX)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .byte_vld (byte_vld),
        .byte_zero(byte_zero),
        .dec_len  (dec_len),
        .wr_en    (wr_en),
        .wr_pos   (wr_pos),
        .pos_q    (pos_q),
        .len_q    (len_q),
        .done_q   (pkt_done)
    );

    pkt_byte_store #(
        .DATA_W   (DATA_W),
        .MAX_BYTES(MAX_BYTES),
        .POS_W    (POS_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .wr_en   (wr_en),
        .wr_pos  (wr_pos),
        .wr_data (byte_in),
        .buf_flat(pkt_buf)
    );

    assign pkt_len = len_q;

endmodule

// File: rtl/pkt_framer_chk.sv
// Module: pkt_framer_chk
// Protocol properties of the framer, bound onto the top module.
// Assumes: synchronous active-low reset; pos_q is the framer's write position.
module pkt_framer_chk #(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 16,
    parameter int POS_W     = 5,
    parameter int LEN_SHORT = 6,
    parameter int LEN_MED   = 11,
    parameter int LEN_LONG  = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        byte_vld,
    input logic [DATA_W-1:0]           byte_in,
    input logic                        restart,
    input logic [MAX_BYTES*DATA_W-1:0] pkt_buf,
    input logic [POS_W-1:0]            pkt_len,
    input logic                        pkt_done,
    input logic [POS_W-1:0]            pos_q
);
    // R1: an idle zero at slot 0 moves nothing
    p_idle_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !restart && pos_q == '0 && byte_in == '0)
        |=> (pos_q == '0 && $stable(pkt_buf)));

    // R2: an accepted byte advances the position, or completes the packet and rewinds it
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !restart && byte_in != '0)
        |=> (pos_q == $past(pos_q) + 1'b1 || (pos_q == '0 && pkt_done)));

    // R3: only the legal sizes, or zero, appear
    p_len_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_len == '0 || pkt_len == POS_W'(LEN_SHORT) ||
         pkt_len == POS_W'(LEN_MED) || pkt_len == POS_W'(LEN_LONG)));

    // R4: the completion pulse lasts one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    // R5: at completion the position and length are already rewound
    p_done_rewound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len == '0 && pos_q == '0));

    // R6: restart empties everything
    p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pkt_buf == '0 && pkt_len == '0 && pos_q == '0 && !pkt_done));

    // R7: no size before the third byte is held
    p_len_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q < POS_W'(3)) |-> (pkt_len == '0));

endmodule

bind pkt_framer pkt_framer_chk #(
    .DATA_W   (DATA_W),
    .MAX_BYTES(MAX_BYTES),
    .POS_W    (POS_W),
    .LEN_SHORT(LEN_SHORT),
    .LEN_MED  (LEN_MED),
    .LEN_LONG (LEN_LONG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_vld(byte_vld),
    .byte_in (byte_in),
    .restart (restart),
    .pkt_buf (pkt_buf),
    .pkt_len (pkt_len),
    .pkt_done(pkt_done),
    .pos_q   (pos_q)
);

// File: tb/tb_pkt_framer.sv
// Bench for pkt_framer: the driver task updates a reference model of the
// buffer and queues every packet it expects to complete; a monitor pops
// the queue on each completion pulse and compares.
module tb_pkt_framer;
    localparam int NB = 16;
    localparam int BW = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_in = '0;
    logic          restart = 1'b0;
    logic [BW-1:0] pkt_buf;
    logic [4:0]    pkt_len;
    logic          pkt_done;

    pkt_framer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_vld(byte_vld),
        .byte_in (byte_in),
        .restart (restart),
        .pkt_buf (pkt_buf),
        .pkt_len (pkt_len),
        .pkt_done(pkt_done)
    );

    always #5 clk = ~clk;

    int            n_chk = 0;
    int            n_fail = 0;
    logic [BW-1:0] exp_buf = '0;
    int            mpos = 0;
    int            mlen = 0;
    logic [BW-1:0] exp_q[$];
    logic [BW-1:0] popped;
    logic          prev_done = 1'b0;

    task automatic chk(input bit ok, input string req,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int size_for(input logic [7:0] c);
        if (!c[7]) return 6;
        return c[6] ? 16 : 11;
    endfunction

    // Driver: update the model, present one byte, then check buffer and length
    task automatic send(input logic [7:0] b, input string req);
        if (!(mpos == 0 && b == 8'h00)) begin
            exp_buf[mpos*8 +: 8] = b;
            mpos++;
            if (mpos == 3) mlen = size_for(b);
            if (mlen != 0 && mpos == mlen) begin
                exp_q.push_back(exp_buf);
                mpos = 0;
                mlen = 0;
            end
        end
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
        chk(pkt_buf == exp_buf, {req, " buffer"}, pkt_buf, exp_buf);
        chk(pkt_len == 5'(mlen), {req, " length"}, BW'(pkt_len), BW'(mlen));
    endtask

    // Whole packet: nonzero first byte, cmd at slot 2, zero inside medium/long ones
    task automatic send_pkt(input logic [7:0] cmd, input int n,
                            input logic [7:0] seed, input string req);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = seed + 8'(k * 13);
            if (k == 0) b = seed | 8'h01;
            if (k == 2) b = cmd;
            if (n > 6 && k == 5) b = 8'h00;   // R7 zero inside the packet
            if (n == 16 && k == 15) b = 8'h00;
            send(b, req);
        end
    endtask

    task automatic do_restart(input bit with_byte);
        @(negedge clk);
        restart  = 1'b1;
        byte_vld = with_byte;
        byte_in  = 8'h5A;
        @(negedge clk);
        restart  = 1'b0;
        byte_vld = 1'b0;
        exp_buf  = '0;
        mpos     = 0;
        mlen     = 0;
        chk(pkt_buf == '0, "R6 restart clears buffer", pkt_buf, '0);
        chk(pkt_len == '0, "R6 restart clears length", BW'(pkt_len), '0);
    endtask

    // Monitor: every completion pulse matches the next queued packet
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_done) begin
                chk(!prev_done, "R4 pulse lasts one cycle", BW'(prev_done), '0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected completion", BW'(pkt_done), '0);
                end else begin
                    popped = exp_q.pop_front();
                    chk(pkt_buf == popped, "R4 completed packet contents", pkt_buf, popped);
                    chk(pkt_len == '0, "R5 length cleared at completion", BW'(pkt_len), '0);
                end
            end
            prev_done <= pkt_done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pkt_buf == '0, "R8 reset buffer", pkt_buf, '0);
        chk(pkt_len == '0, "R8 reset length", BW'(pkt_len), '0);
        chk(pkt_done == 1'b0, "R8 reset done", BW'(pkt_done), '0);
        rst_n = 1'b1;

        send(8'h00, "R1 idle zero");
        send(8'h00, "R1 idle zero");
        send(8'h20, "R2 first byte");
        send(8'h10, "R7 length unknown");
        send(8'h01, "R3 short 00");
        send(8'h02, "R2 store");
        send(8'h33, "R2 store");
        send(8'h44, "R4 final short byte");
        send(8'h00, "R5 idle after packet keeps buffer");

        send_pkt(8'h41, 6,  8'h30, "R3 pattern 01 short");
        send_pkt(8'h85, 11, 8'h50, "R3 medium");
        send_pkt(8'hC2, 16, 8'h70, "R3 long");
        send_pkt(8'h03, 6,  8'h90, "R5 back to back");

        send(8'h11, "R6 partial");
        send(8'h22, "R6 partial");
        send(8'h83, "R6 partial");
        do_restart(1'b0);
        do_restart(1'b1);
        send_pkt(8'h07, 6, 8'hA0, "R6 packet after restart");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 every packet completed", BW'(exp_q.size()), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule